// File: doc/BRIEF.md
# Sliding-Window RMS Threshold Estimator

This block derives a denoising threshold for one detail band of a wavelet decomposition. Signed detail samples arrive on a valid strobe. Each sample is squared and added to a block accumulator. No mean is removed, because the band is taken to have zero mean. When a block of `BLK_LEN` samples is complete, its sum goes into a four-slot ring. The four stored sums cover a window of `4*BLK_LEN` samples, and that window advances by one block each time.

After each block the ring total is scaled by a fixed-point reciprocal of `(4*BLK_LEN-1)`. A sequential bisection unit takes the integer square root of the scaled value, giving the standard deviation. That root is then multiplied by a fixed-point gain of `sqrt(2 ln M)` to form the threshold. The threshold output moves once per block and is announced by a one-cycle update pulse. A separate valid flag marks when the window holds four real blocks.

The number of cycles from a block's last sample to the update is fixed and does not depend on the data. With the default parameters it is 24 cycles. The next block must end at least that many cycles after the previous one; at normal sample rates this always holds.

Top module: `rms_thresh_est`

## Requirements
- R1: While rst_ni is low and right after it is released, thr_o is 0, thr_upd_o is 0 and thr_vld_o is 0.
- R2: A sample is taken only in a cycle where smp_vld_i is high. smp_i is read as two's complement and its square is added to the block sum. Data present while smp_vld_i is low has no effect on any threshold.
- R3: Every BLK_LEN (default 8) valid samples close a block. Its sum overwrites the oldest of four ring slots. The window total is the sum of the four slots, and slots not yet written since reset count as zero.
- R4: The scaled target is floor(window_total * INV_K / 2^INV_FRAC), with defaults INV_K = 2114 and INV_FRAC = 16.
- R5: The root is floor(sqrt(target)). It is found by bisection over a fixed number of iterations, equal to the root width (19 with defaults).
- R6: The threshold is floor(root * GAIN_K / 2^GAIN_FRAC), with defaults GAIN_K = 674 and GAIN_FRAC = 8.
- R7: thr_upd_o is a single-cycle pulse. It is seen in the 24th cycle after the clock edge that takes a block's last sample, whatever the data.
- R8: thr_vld_o stays low for the updates from the first three blocks after reset. It rises together with the update from the fourth block and then stays high.
- R9: thr_o holds its value between update pulses.
- R10: Blocks made only of full-scale samples (-32768 or +/-32767) are accumulated, rooted and scaled without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | DATA_W (16) | Signed detail sample |
| thr_o | output | RT_W+GAIN_INT_W (23) | Threshold value |
| thr_upd_o | output | 1 | One-cycle pulse when thr_o is refreshed |
| thr_vld_o | output | 1 | Window holds four real blocks |

## Verification
The hardest state to reach from the ports is a ring that has wrapped. In that state every slot holds a different, nonzero sum, and the oldest slot must be the one replaced. The stimulus table runs seven blocks of different amplitude, offset and sign pattern, so the last three updates each drop a distinct older block. It includes an all-zero block and full-scale blocks, so the window total reaches its largest values. A reset is then applied mid-stream and one more block is sent, to show that the emptied slots again count as zero.

// File: rtl/thr_est_pkg.sv
package thr_est_pkg;
  localparam int unsigned RING_SLOTS = 4;

  function automatic int unsigned half_up(input int unsigned w);
    return (w + 1) / 2;
  endfunction
endpackage

// File: rtl/thr_sq_accum.sv
module thr_sq_accum #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned BLK_LEN = 8,
  parameter int unsigned ACC_W   = 35
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              blk_vld_o,
  output logic [ACC_W-1:0]  blk_sum_o
);
  localparam int unsigned CNT_W = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam int unsigned SQ_W  = 2 * DATA_W;

  logic signed [SQ_W-1:0] sq_s;
  logic [ACC_W-1:0]       sq_u, acc_q, sum_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   last, bv_q;

  assign sq_s = $signed(data_i) * $signed(data_i);
  assign sq_u = {{(ACC_W-SQ_W){1'b0}}, sq_s};
  assign last = (cnt_q == CNT_W'(BLK_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sum_q <= '0;
      cnt_q <= '0;
      bv_q  <= 1'b0;
    end else begin
      bv_q <= 1'b0;
      if (vld_i) begin
        if (last) begin
          sum_q <= acc_q + sq_u;
          acc_q <= '0;
          cnt_q <= '0;
          bv_q  <= 1'b1;
        end else begin
          acc_q <= acc_q + sq_u;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign blk_vld_o = bv_q;
  assign blk_sum_o = sum_q;

  // R3: accumulator restarts whenever a block closes
  p_acc_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bv_q |-> (acc_q == '0 && cnt_q == '0));
  // R2: squares never decrease the running sum
  p_acc_mono_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !last) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/thr_win_ring.sv
module thr_win_ring #(
  parameter int unsigned ACC_W   = 35,
  parameter int unsigned NUM_BLK = 4,
  parameter int unsigned SUM_W   = 37
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blk_vld_i,
  input  logic [ACC_W-1:0] blk_sum_i,
  output logic             win_vld_o,
  output logic [SUM_W-1:0] win_sum_o,
  output logic             full_o
);
  localparam int unsigned WP_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
  localparam int unsigned FILL_W = $clog2(NUM_BLK + 1);

  logic [ACC_W-1:0]  slot_w [NUM_BLK];
  logic [WP_W-1:0]   wp_q;
  logic [FILL_W-1:0] fill_q;
  logic              go_q, wv_q;
  logic [SUM_W-1:0]  tot, ws_q;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_slot
    logic [ACC_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= '0;
      else if (blk_vld_i && wp_q == WP_W'(g))       q <= blk_sum_i;
    end
    assign slot_w[g] = q;
  end

  always_comb begin
    tot = '0;
    for (int i = 0; i < NUM_BLK; i++) tot = tot + SUM_W'(slot_w[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      fill_q <= '0;
      go_q   <= 1'b0;
      wv_q   <= 1'b0;
      ws_q   <= '0;
    end else begin
      go_q <= blk_vld_i;
      wv_q <= go_q;
      if (go_q) ws_q <= tot;
      if (blk_vld_i) begin
        wp_q <= (wp_q == WP_W'(NUM_BLK - 1)) ? '0 : wp_q + 1'b1;
        if (fill_q != FILL_W'(NUM_BLK)) fill_q <= fill_q + 1'b1;
      end
    end
  end

  assign win_vld_o = wv_q;
  assign win_sum_o = ws_q;
  assign full_o    = (fill_q == FILL_W'(NUM_BLK));

  p_fill_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_W'(NUM_BLK));
  p_wp_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_vld_i |=> (wp_q != $past(wp_q)));
endmodule

// File: rtl/thr_bisect_sqrt.sv
module thr_bisect_sqrt #(
  parameter int unsigned IN_W = 37,
  parameter int unsigned RT_W = 19
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [IN_W-1:0] val_i,
  output logic            done_o,
  output logic [RT_W-1:0] root_o
);
  localparam int unsigned IT_W = $clog2(RT_W + 1);
  localparam int unsigned SQ_W = 2 * (RT_W + 1);

  logic [RT_W:0]   lo_q, hi_q, mid;
  logic [RT_W+1:0] mid_sum;
  logic [SQ_W-1:0] mid_sq, tgt_x;
  logic [IN_W-1:0] tgt_q;
  logic [IT_W-1:0] it_q;
  logic            busy_q, done_q;

  assign mid_sum = {1'b0, lo_q} + {1'b0, hi_q};
  assign mid     = mid_sum[RT_W+1:1];
  assign mid_sq  = SQ_W'(mid) * SQ_W'(mid);
  assign tgt_x   = SQ_W'(tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      tgt_q  <= '0;
      it_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        lo_q   <= '0;
        hi_q   <= {1'b1, {RT_W{1'b0}}};
        tgt_q  <= val_i;
        it_q   <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (mid_sq <= tgt_x) lo_q <= mid;
        else                 hi_q <= mid;
        it_q <= it_q + 1'b1;
        if (it_q == IT_W'(RT_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign root_o = lo_q[RT_W-1:0];

  p_root_exact_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ((SQ_W'(lo_q) * SQ_W'(lo_q) <= tgt_x) &&
                ((SQ_W'(lo_q) + 1) * (SQ_W'(lo_q) + 1) > tgt_x)));
  p_start_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/rms_thresh_est.sv
module rms_thresh_est
  import thr_est_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned BLK_LEN    = 8,
  parameter int unsigned INV_FRAC   = 16,
  parameter int unsigned INV_K      = 2114,
  parameter int unsigned GAIN_INT_W = 4,
  parameter int unsigned GAIN_FRAC  = 8,
  parameter int unsigned GAIN_K     = 674,
  localparam int unsigned ACC_W     = 2 * DATA_W + $clog2(BLK_LEN),
  localparam int unsigned SUM_W     = ACC_W + $clog2(RING_SLOTS),
  localparam int unsigned TGT_W     = SUM_W,
  localparam int unsigned RT_W      = half_up(TGT_W),
  localparam int unsigned THR_W     = RT_W + GAIN_INT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] smp_i,
  output logic [THR_W-1:0]  thr_o,
  output logic              thr_upd_o,
  output logic              thr_vld_o
);
  localparam int unsigned GK_W = GAIN_INT_W + GAIN_FRAC;
  localparam int unsigned TP_W = SUM_W + INV_FRAC;
  localparam int unsigned GP_W = RT_W + GK_W;

  logic             blk_vld, win_vld, full, go_q, rt_done;
  logic [ACC_W-1:0] blk_sum;
  logic [SUM_W-1:0] win_sum;
  logic [TP_W-1:0]  tprod;
  logic [TGT_W-1:0] tgt_q;
  logic [RT_W-1:0]  root;
  logic [GP_W-1:0]  gprod;
  logic [THR_W-1:0] thr_q;
  logic             upd_q, vld_q;

  thr_sq_accum #(.DATA_W(DATA_W), .BLK_LEN(BLK_LEN), .ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni, .vld_i(smp_vld_i), .data_i(smp_i),
    .blk_vld_o(blk_vld), .blk_sum_o(blk_sum));

  thr_win_ring #(.ACC_W(ACC_W), .NUM_BLK(RING_SLOTS), .SUM_W(SUM_W)) u_ring (
    .clk_i, .rst_ni, .blk_vld_i(blk_vld), .blk_sum_i(blk_sum),
    .win_vld_o(win_vld), .win_sum_o(win_sum), .full_o(full));

  assign tprod = TP_W'(win_sum) * TP_W'(INV_K);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
      go_q  <= 1'b0;
    end else begin
      go_q <= win_vld;
      if (win_vld) tgt_q <= tprod[INV_FRAC +: TGT_W];
    end
  end

  thr_bisect_sqrt #(.IN_W(TGT_W), .RT_W(RT_W)) u_sqrt (
    .clk_i, .rst_ni, .start_i(go_q), .val_i(tgt_q),
    .done_o(rt_done), .root_o(root));

  assign gprod = GP_W'(root) * GP_W'(GAIN_K);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= '0;
      upd_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      upd_q <= rt_done;
      if (rt_done) begin
        thr_q <= gprod[GAIN_FRAC +: THR_W];
        if (full) vld_q <= 1'b1;
      end
    end
  end

  assign thr_o     = thr_q;
  assign thr_upd_o = upd_q;
  assign thr_vld_o = vld_q;

  p_upd_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);
  p_vld_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> vld_q);
  p_thr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q != $past(thr_q)) |-> upd_q);
  p_vld_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_q) |-> (upd_q && full));
endmodule

// File: tb/rms_thresh_est_tb_top.sv
module rms_thresh_est_tb_top;
  localparam int  BLK  = 8;
  localparam int  LAT  = 24;
  localparam int  NTAB = 7;
  localparam logic [15:0] JUNK = 16'h7abc;
  localparam int TAB_AMP [NTAB] = '{100, 2000, 0, 12345, -32768, 32767, 1};
  localparam int TAB_OFF [NTAB] = '{3, -50, 0, 7, 0, 0, 0};
  localparam int TAB_ALT [NTAB] = '{1, 1, 0, 1, 0, 1, 1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] smp = '0;
  logic [22:0] thr;
  logic        upd, tvld;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  longint hist [4];
  int wp = 0;
  int nblk = 0;

  always #2.5 clk = ~clk;

  rms_thresh_est dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_i(smp),
    .thr_o(thr), .thr_upd_o(upd), .thr_vld_o(tvld));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint t);
    longint r = longint'($floor($sqrt(real'(t))));
    while (r * r > t) r--;
    while ((r + 1) * (r + 1) <= t) r++;
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) hist[i] = 0;
    wp = 0;
    nblk = 0;
  endtask

  task automatic run_block(input int amp, input int off, input int alt, input string tag);
    longint bsum = 0;
    longint wsum, tgt, root, exp_thr;
    int first = -1;
    bit upd_after = 1'b0;
    logic [22:0] cap_thr = '0;
    logic cap_vld = 1'b0;
    for (int k = 0; k < BLK; k++) begin
      int x = amp + off * k;
      logic signed [15:0] s;
      if (alt != 0 && k % 2 == 1) x = -x;
      s = 16'(x);
      bsum += longint'(s) * longint'(s);
      @(negedge clk); vld = 1'b1; smp = s;
      @(negedge clk); vld = 1'b0; smp = JUNK;
      if (k < BLK - 1) repeat (3) @(negedge clk);
    end
    hist[wp] = bsum;
    wp = (wp + 1) % 4;
    nblk++;
    wsum = hist[0] + hist[1] + hist[2] + hist[3];
    tgt = (wsum * 2114) >>> 16;
    root = isqrt(tgt);
    exp_thr = (root * 674) >>> 8;
    for (int idx = 1; idx <= 40; idx++) begin
      @(negedge clk);
      if (idx == first + 1 && first > 0) upd_after = upd;
      if (upd && first < 0) begin
        first = idx;
        cap_thr = thr;
        cap_vld = tvld;
      end
    end
    chk(first == LAT, {"R7 latency ", tag}, first, LAT);
    chk(!upd_after, {"R7 pulse width ", tag}, upd_after, 0);
    chk(cap_thr == 23'(exp_thr), {"R2 R3 R4 R5 R6 R10 value ", tag}, cap_thr, exp_thr);
    chk(cap_vld == (nblk >= 4), {"R8 valid ", tag}, cap_vld, (nblk >= 4));
    chk(thr == cap_thr, {"R9 hold ", tag}, thr, cap_thr);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk(thr == 0 && !upd && !tvld, "R1 in reset", {thr, upd, tvld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(thr == 0 && !upd && !tvld, "R1 after release", {thr, upd, tvld}, 0);
    for (int i = 0; i < NTAB; i++)
      run_block(TAB_AMP[i], TAB_OFF[i], TAB_ALT[i], $sformatf("tab%0d", i));
    // directed: mid-stream reset empties the ring
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(thr == 0 && !upd && !tvld, "R1 re-reset", {thr, upd, tvld}, 0);
    rst_n = 1'b1;
    model_reset();
    run_block(500, -9, 1, "post_reset");
    // directed: junk on idle strobes only, then zero block keeps ring sum
    run_block(0, 0, 0, "zero_blk");
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule